// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a short burst to a pipelined memory. When a load cycle comes, it takes a full starting address. On each following advance cycle it steps only the low burst bits, and the upper bits keep the values they had at the load. The low bits can step in linear order, which is a wrapping increment, or in interleaved order, where the beat number is XORed into the starting low bits. The order is chosen by a mode input and is fixed at the time of the load.

The output address is registered. It takes the new value in the cycle after the edge where the command was seen. A clock enable qualifies every edge. While it is low, the block ignores load, advance, mode and the address input, and the output holds. The default burst length is four beats, which uses two low bits.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, addr_out is zero. Advance order is linear and the starting low bits are zero.
- R2: An edge with clk_en=1 and load=1 makes addr_out equal start_addr after that edge. That output is beat 0.
- R3: The mode input interleave is sampled only on load edges (1 = interleaved, 0 = linear). A change of interleave on advance edges has no effect on addr_out.
- R4: In linear order, beat n has low bits (S + n) mod 4. S is the starting low bits, addr_out[1:0].
- R5: In interleaved order, beat n has low bits S XOR n.
- R6: An advance edge (clk_en=1, load=0) never changes addr_out bits above bit 1.
- R7: An advance after beat 3 gives beat 0 again, which is the starting low bits. The sequence then repeats.
- R8: On an edge with clk_en=0, addr_out does not change. No internal state changes either, whatever the values of load, interleave and start_addr.
- R9: Advances after reset with no load step from address zero in linear order: 0, 1, 2, 3, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Qualifies each edge; 0 freezes the block |
| load | input | 1 | 1 = load start_addr, 0 = advance burst |
| interleave | input | 1 | Burst order taken at load: 1 interleaved, 0 linear |
| start_addr | input | ADDR_W | Starting address captured on load |
| addr_out | output | ADDR_W | Registered address of the current beat |

## Verification
The assertions assume that clk_en, load, interleave and start_addr are always driven to known values after reset. They also assume these inputs change only between rising edges, so the value sampled at an edge is the value that was meant. The bench follows both rules. It drives every input from its tasks on the falling edge, starting from the reset state. It then mixes directed bursts with random command streams. In those streams, interleave flips freely between loads and clk_en drops in the middle of a burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic {
        ORD_LINEAR      = 1'b0,
        ORD_INTERLEAVED = 1'b1
    } burst_order_e;

endpackage

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr #(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [BEAT_W-1:0] beat_q,
    output logic [BEAT_W-1:0] beat_nx
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}};

    logic [BEAT_W-1:0] beat_d;

    always_comb begin
        beat_d = beat_q;
        if (restart) begin
            beat_d = '0;
        end else if (step) begin
            beat_d = beat_q + 1'b1;
        end
    end

    assign beat_nx = beat_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
        end else begin
            beat_q <= beat_d;
        end
    end

    // R7
    wrap_to_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && beat_q == LAST_BEAT) |=> (beat_q == '0));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(beat_q));

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] first_low,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;

    assign lin_low = first_low + beat;

    genvar gi;
    generate
        for (gi = 0; gi < BEAT_W; gi++) begin : g_ilv_bit
            assign ilv_low[gi] = first_low[gi] ^ beat[gi];
        end
    endgenerate

    always_comb begin
        low = (order == ORD_INTERLEAVED) ? ilv_low : lin_low;
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              load,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [BEAT_W-1:0] first_low;
        logic [BEAT_W-1:0] cur_low;
        burst_order_e      order;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic              do_load;
    logic              do_step;
    logic [BEAT_W-1:0] beat_q;
    logic [BEAT_W-1:0] beat_nx;
    logic [BEAT_W-1:0] mapped_low;

    assign do_load = clk_en && load;
    assign do_step = clk_en && !load;

    bseq_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (do_load),
        .step    (do_step),
        .beat_q  (beat_q),
        .beat_nx (beat_nx)
    );

    bseq_order_map #(.BEAT_W(BEAT_W)) u_map (
        .first_low (st_q.first_low),
        .beat      (beat_nx),
        .order     (st_q.order),
        .low       (mapped_low)
    );

    always_comb begin
        st_d = st_q;
        if (do_load) begin
            st_d.hi        = start_addr[ADDR_W-1:BEAT_W];
            st_d.first_low = start_addr[BEAT_W-1:0];
            st_d.cur_low   = start_addr[BEAT_W-1:0];
            st_d.order     = interleave ? ORD_INTERLEAVED : ORD_LINEAR;
        end else if (do_step) begin
            st_d.cur_low   = mapped_low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{hi: '0, first_low: '0, cur_low: '0, order: ORD_LINEAR};
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_out = {st_q.hi, st_q.cur_low};

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && load) |=> (addr_out == $past(start_addr)));

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(addr_out));

    // R6
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load) |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && st_q.order == ORD_LINEAR)
        |=> (addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + 1'b1));

    // R5
    interleave_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !load && st_q.order == ORD_INTERLEAVED)
        |=> ((addr_out[BEAT_W-1:0] ^ st_q.first_low) == beat_q));

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b0;
    logic          load = 1'b0;
    logic          interleave = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int m_start = 0;
    int m_beat  = 0;
    bit m_ilv   = 1'b0;

    always #5 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .load       (load),
        .interleave (interleave),
        .start_addr (start_addr),
        .addr_out   (addr_out)
    );

    function automatic int expected_addr();
        int lo;
        int s;
        s  = m_start & 3;
        lo = m_ilv ? (s ^ m_beat) : ((s + m_beat) % 4);
        return (m_start & ~3) | lo;
    endfunction

    task automatic check(input string tag, input int exp_v);
        checks++;
        if (int'(addr_out) !== exp_v) begin
            errors++;
            $display("FAIL %s addr_out actual %0h expected %0h", tag, addr_out, exp_v);
        end
    endtask

    // called at a falling edge; drives one command, models it, checks after output settles
    task automatic step(input bit ce, input bit ld, input bit il, input int a, input string tag);
        clk_en = ce; load = ld; interleave = il; start_addr = AW'(a);
        @(posedge clk);
        if (ce && ld) begin
            m_start = a & ((1 << AW) - 1); m_beat = 0; m_ilv = il;
        end else if (ce) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag, expected_addr());
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0);

        // R9: advance from reset state, linear from zero
        for (int i = 0; i < 5; i++) step(1, 0, 1, 'h5a5a5, "R9 advance from reset");

        // R2 / R4 / R7: linear from low bits 1
        step(1, 1, 0, 'h12341, "R2 load linear");
        for (int i = 0; i < 6; i++) step(1, 0, 0, 'hfffff, "R4 R7 R6 linear beat");

        // R5 / R7: interleaved from low bits 2
        step(1, 1, 1, 'hab9e, "R2 load interleaved");
        for (int i = 0; i < 5; i++) step(1, 0, 1, 'h0, "R5 R7 interleaved beat");

        // R3: mode toggled during advances is ignored
        step(1, 1, 0, 'h3, "R2 load linear start 3");
        for (int i = 0; i < 4; i++) step(1, 0, 1, 'h0, "R3 mode ignored on advance");
        step(1, 1, 1, 'h7, "R2 load interleaved start 3");
        for (int i = 0; i < 4; i++) step(1, 0, 0, 'h0, "R3 mode ignored interleaved");

        // R8: clk_en low blocks loads and advances
        step(1, 0, 0, 'h0, "R5 advance before freeze");
        step(0, 1, 0, 'hcccc0, "R8 frozen load");
        step(0, 0, 1, 'h11111, "R8 frozen advance");
        step(1, 0, 0, 'h0, "R8 resume advance");

        // random command streams
        for (int i = 0; i < 400; i++) begin
            int r;
            r = $urandom;
            step((r % 5) != 0, ((r >> 4) % 4) == 0, r[8], $urandom & 'hfffff, "R4 R5 R8 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule